// File: doc/BRIEF.md
# Interrupt Flag and Event Counter Bank

This block is the host-facing interrupt logic of a network controller. It keeps eight latched event flags and an eight-bit mask. Five flags are set directly by single-cycle pulses from the MAC: jabber, babble, collision error, receive done and transmit done. The other three are set when one of three free-running 8-bit event counters wraps. The counters track received collisions, runt frames and missed frames that matched the station address.

A registered, active-low interrupt line is asserted while any unmasked flag is set. The host reads flags, mask and counters through a small synchronous port with an address, a read strobe and a write strobe. Reading the flag register or any counter clears it. The host can only write the mask. A synchronous soft-reset input clears all state, as the hardware reset does.

Read data is combinational. It is valid in the cycle the read strobe is high, and the clear takes effect at the end of that cycle. Address map: 0 flags, 1 mask, 2 collision counter, 3 runt counter, 4 missed counter. Any other address reads as zero.

Top module: `irq_event_bank`

## Requirements
- R1: After hardware reset, the flags, mask and all three counters read 0 and `irq_n` is 1.
- R2: Flag bit positions are: bit7 jabber, bit6 babble, bit5 collision error, bit4 collision-counter wrap, bit3 runt-counter wrap, bit2 missed-counter wrap, bit1 receive, bit0 transmit. An event pulse sets its bit.
- R3: A read of address 0 returns the flags and then clears them. A flag whose event arrives in the same cycle as that read stays set.
- R4: Writes to address 0 have no effect on the flags.
- R5: The mask at address 1 is read/write and uses the flag bit positions. A set mask bit keeps its flag from asserting `irq_n`, but the flag still latches.
- R6: `irq_n` is registered. It is 0 in the cycle after any edge that leaves some flag set whose mask bit is 0, and 1 otherwise.
- R7: Each counter adds one per event pulse. A read returns the count and clears the counter to 0. If an event arrives in the same cycle as the read, the counter becomes 1.
- R8: A counter increment from 255 wraps to 0 and sets that counter's wrap flag, whether or not the flag is masked.
- R9: The missed counter advances only when `ev_missed` and `ev_missed_match` are both high.
- R10: `soft_rst` high at an edge clears the flags, mask and counters and sets `irq_n` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous clear of all state |
| addr | input | 3 | Register address |
| rd_en | input | 1 | Read strobe; clears the addressed flag or counter register |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid while rd_en is high |
| ev_jabber | input | 1 | Jabber event pulse |
| ev_babble | input | 1 | Babble event pulse |
| ev_colerr | input | 1 | Collision error pulse |
| ev_rcvcol | input | 1 | Received collision pulse |
| ev_runt | input | 1 | Runt frame pulse |
| ev_missed | input | 1 | Missed frame pulse |
| ev_missed_match | input | 1 | Missed frame matched the station address |
| ev_rx | input | 1 | Receive done pulse |
| ev_tx | input | 1 | Transmit done pulse |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The wrap flags are the hardest to reach. Each one needs 256 event pulses with no read of that counter in between. The stimulus first clears the counter with a read, then drives a run of 256 pulses. Before the read it checks both the flag and the interrupt line, once with the wrap bit masked and once unmasked. The collisions of a read with a new event, on the flag register and on a counter, are produced by asserting the event pulse and the read strobe in the same cycle.

// File: rtl/irq_event_bank.sv
module irq_event_bank #(
  parameter int DW = 8,
  parameter int AW = 3,
  parameter int NCNT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic [AW-1:0] addr,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic          ev_jabber,
  input  logic          ev_babble,
  input  logic          ev_colerr,
  input  logic          ev_rcvcol,
  input  logic          ev_runt,
  input  logic          ev_missed,
  input  logic          ev_missed_match,
  input  logic          ev_rx,
  input  logic          ev_tx,
  output logic          irq_n
);
  localparam logic [AW-1:0] A_FLAGS = AW'(0);
  localparam logic [AW-1:0] A_MASK  = AW'(1);
  localparam int CNT_BASE = 2;

  logic [DW-1:0]      flags, mask;
  logic [NCNT*DW-1:0] cnt_all;
  logic [NCNT-1:0]    inc, wrap;

  assign inc = {ev_missed & ev_missed_match, ev_runt, ev_rcvcol};

  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    logic [DW-1:0] c;
    wire clr = rd_en && (addr == AW'(CNT_BASE + i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        c <= '0;
      else if (soft_rst) c <= '0;
      else if (clr)      c <= {{(DW-1){1'b0}}, inc[i]};
      else if (inc[i])   c <= c + 1'b1;
    end
    assign wrap[i] = inc[i] && !clr && (&c);
    assign cnt_all[i*DW +: DW] = c;
  end

  wire [DW-1:0] set_vec = {ev_jabber, ev_babble, ev_colerr,
                           wrap[0], wrap[1], wrap[2], ev_rx, ev_tx};
  wire rd_flags = rd_en && (addr == A_FLAGS);

  wire [DW-1:0] flags_nx = soft_rst ? '0 : ((rd_flags ? '0 : flags) | set_vec);
  wire [DW-1:0] mask_nx  = soft_rst ? '0 :
                           ((wr_en && addr == A_MASK) ? wr_data : mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      mask  <= '0;
      irq_n <= 1'b1;
    end else begin
      flags <= flags_nx;
      mask  <= mask_nx;
      irq_n <= ~|(flags_nx & ~mask_nx);
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      if (addr == A_FLAGS)     rd_data = flags;
      else if (addr == A_MASK) rd_data = mask;
      else
        for (int k = 0; k < NCNT; k++)
          if (addr == AW'(CNT_BASE + k)) rd_data = cnt_all[k*DW +: DW];
    end
  end
endmodule

// File: rtl/irq_event_bank_chk.sv
module irq_event_bank_chk #(
  parameter int DW = 8,
  parameter int AW = 3,
  parameter int NCNT = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              soft_rst,
  input logic              rd_en,
  input logic [AW-1:0]     addr,
  input logic              ev_rcvcol,
  input logic              ev_missed,
  input logic              ev_missed_match,
  input logic [DW-1:0]     flags,
  input logic [DW-1:0]     mask,
  input logic [NCNT*DW-1:0] cnt_all,
  input logic              irq_n
);
  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n == ~|(flags & ~mask)); // R6

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst && !(rd_en && addr == AW'(0))) |=> ((flags & $past(flags)) == $past(flags))); // R3

  AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (flags == '0 && mask == '0 && cnt_all == '0 && irq_n)); // R10

  AST_MISS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_missed && !ev_missed_match && !soft_rst && !(rd_en && addr == AW'(4)))
      |=> $stable(cnt_all[2*DW +: DW])); // R9

  AST_COL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rcvcol && (&cnt_all[DW-1:0]) && !soft_rst && !(rd_en && addr == AW'(2)))
      |=> (flags[4] && cnt_all[DW-1:0] == '0)); // R8
endmodule

bind irq_event_bank irq_event_bank_chk #(.DW(DW), .AW(AW), .NCNT(NCNT)) chk_i (.*);

// File: tb/irq_event_bank_tb_top.sv
module irq_event_bank_tb_top;
  logic clk = 0, rst_n = 0, soft_rst = 0, rd_en = 0, wr_en = 0;
  logic [2:0] addr = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic irq_n;
  // ev bits: 0 tx,1 rx,2 missed,3 runt,4 rcvcol,5 colerr,6 babble,7 jabber,8 missed_match
  logic [8:0] ev = 0;
  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  irq_event_bank dut_i (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .addr(addr), .rd_en(rd_en),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .ev_jabber(ev[7]), .ev_babble(ev[6]), .ev_colerr(ev[5]), .ev_rcvcol(ev[4]),
    .ev_runt(ev[3]), .ev_missed(ev[2]), .ev_missed_match(ev[8]),
    .ev_rx(ev[1]), .ev_tx(ev[0]), .irq_n(irq_n));

  always @(negedge clk) begin
    if (rd_en && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (rd_data !== e) begin
        n_fail++;
        $display("FAIL %s addr=%0d actual=%02h expected=%02h", t, addr, rd_data, e);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic rd_ev(input logic [2:0] a, input logic [8:0] v,
                       input logic [7:0] e, input string t);
    addr = a; rd_en = 1; ev = v;
    exp_q.push_back(e); tag_q.push_back(t);
    tick();
    rd_en = 0; ev = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string t);
    rd_ev(a, 9'h0, e, t);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1;
    tick();
    wr_en = 0;
  endtask

  task automatic pulse(input logic [8:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      ev = v; tick();
    end
    ev = 0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    n_chk++;
    if (irq_n !== e) begin
      n_fail++;
      $display("FAIL %s irq_n actual=%b expected=%b", t, irq_n, e);
    end
  endtask

  initial begin
    #500000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    tick(); tick();
    rst_n = 1;
    tick();
    chk_irq(1'b1, "R1 reset irq");
    rd(0, 8'h00, "R1 flags"); rd(1, 8'h00, "R1 mask");
    rd(2, 8'h00, "R1 col"); rd(3, 8'h00, "R1 runt"); rd(4, 8'h00, "R1 miss");

    pulse(9'h080, 1);
    chk_irq(1'b0, "R6 jabber asserts");
    rd(0, 8'h80, "R2 jabber bit");
    chk_irq(1'b1, "R6 released after clear");
    rd(0, 8'h00, "R3 cleared by read");
    pulse(9'h063, 1);
    rd(0, 8'h63, "R2 babble colerr rx tx");

    pulse(9'h001, 1);
    wr(0, 8'h00);
    rd(0, 8'h01, "R4 write zero ignored");
    wr(0, 8'hFF);
    rd(0, 8'h00, "R4 write ones ignored");

    wr(1, 8'h01);
    rd(1, 8'h01, "R5 mask readback");
    pulse(9'h001, 1);
    chk_irq(1'b1, "R5 masked flag no irq");
    pulse(9'h002, 1);
    chk_irq(1'b0, "R6 unmasked rx");
    rd(0, 8'h03, "R5 masked flag latched");
    wr(1, 8'h00);

    rd_ev(0, 9'h001, 8'h00, "R3 read with event");
    rd(0, 8'h01, "R3 event kept");

    pulse(9'h010, 3);
    rd(2, 8'h03, "R7 col count");
    rd(2, 8'h00, "R7 col cleared");
    pulse(9'h008, 2);
    rd(3, 8'h02, "R7 runt count");
    pulse(9'h104, 1);
    pulse(9'h004, 2);
    pulse(9'h100, 2);
    rd(4, 8'h01, "R9 missed needs match");
    pulse(9'h010, 1);
    rd_ev(2, 9'h010, 8'h01, "R7 read with event");
    rd(2, 8'h01, "R7 event kept");

    wr(1, 8'hFF);
    pulse(9'h010, 256);
    chk_irq(1'b1, "R8 masked wrap no irq");
    rd(2, 8'h00, "R8 col wrapped");
    rd(0, 8'h10, "R8 col wrap flag masked");
    wr(1, 8'h00);
    pulse(9'h008, 256);
    chk_irq(1'b0, "R8 runt wrap irq");
    rd(0, 8'h08, "R8 runt wrap flag");
    pulse(9'h104, 255);
    rd(0, 8'h00, "R8 no flag at 255");
    pulse(9'h104, 1);
    rd(0, 8'h04, "R8 missed wrap flag");

    wr(1, 8'h55);
    pulse(9'h092, 1);
    soft_rst = 1; tick(); soft_rst = 0;
    chk_irq(1'b1, "R10 irq after soft reset");
    rd(0, 8'h00, "R10 flags"); rd(1, 8'h00, "R10 mask");
    rd(2, 8'h00, "R10 col");

    tick();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule